// File: doc/BRIEF.md
# Four-Beat Double-Data-Rate Dual-Port SRAM

This block is a small synchronous memory with one read data bus and one write data bus. Both buses move one beat on every half cycle, and every access is a fixed burst of four beats. Each array word is four beats wide. Write beats are gathered in a collector and stored with one masked write. A read fetches one whole word and sends it back as four beats, marked by a valid flag.

The two edges of the external clock are modelled with one internal clock at twice the rate. An input marks which half of the external cycle the coming tick belongs to. A "cycle" below means two ticks. Commands are sampled only on ticks of the first half. Read and write share one burst address bus, and they can be issued together. A read always sees every write that was issued before it or in the same cycle, including a write whose beats are still arriving.

Top module: `ddr_burst4_sram`

## Requirements
- R1: A read command and a write command may be given on the same tick. Both are accepted, and each runs on its own data bus.
- R2: `rd_en` and `wr_en` are sampled only on ticks where `phase` is 0. A command on a tick where `phase` is 1 has no effect on memory contents or on the read outputs.
- R3: An accepted write takes beat 0 from `wr_data` on the command tick and beats 1 to 3 on the next three ticks. Beat k fills bits k*DATA_W up to k*DATA_W+DATA_W-1 of the stored word. The word is written into the array in one operation.
- R4: `wr_be` is sampled with each beat. Bit l enables bits l*9 to l*9+8 of that beat. A lane whose bit is 0 keeps its previous contents.
- R5: `addr` selects one four-beat word out of 2^ADDR_W, and different addresses hold independent words.
- R6: Beat 0 of a read appears on `rd_data` five ticks after the command tick, which is two and a half cycles. Beats 1 to 3 follow on the next three ticks, and `rd_valid` is high on exactly those four ticks.
- R7: A read returns the effect of every write commanded on an earlier tick or on the same tick as the read, with lane masks applied. It does not return the effect of a write commanded after it.
- R8: Each port accepts at most one burst every four ticks. A command to a port whose burst started less than four ticks earlier is ignored. Reads accepted four ticks apart give an unbroken run of eight valid beats.
- R9: On a tick that carries no read beat, `rd_valid` is 0 and `rd_data` keeps its last value.
- R10: During and after reset, `rd_valid` is 0, `rd_data` is 0 and no burst is in progress. The array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the external rate; one tick per beat |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 1 | 0 on the tick where commands may be sampled, 1 on the other |
| rd_en | input | 1 | Read burst request |
| wr_en | input | 1 | Write burst request |
| addr | input | ADDR_W | Burst word address shared by both ports |
| wr_data | input | DATA_W | Write beat |
| wr_be | input | DATA_W/9 | Per-beat enables, one bit per 9-bit lane |
| rd_data | output | DATA_W | Read beat |
| rd_valid | output | 1 | High while rd_data carries a read beat |

## Verification
The bench aims at the ordering corners of the coherence rule. These are a read and a write to the same word on the same tick, a write one cycle before a read, and a read one cycle before a write. If the in-flight write were not forwarded, the read would return stale data. If the fetch came too late, a later write would leak into an earlier read. The bench also gives commands on the wrong phase and while a burst is still busy, and it uses masks that differ from beat to beat. Beat timing is checked against the tick count. A latency that is off by one tick, or a gap between back-to-back reads, therefore shows up as a mismatch.

// File: rtl/ddrb4_pkg.sv
`timescale 1ns/1ps
package ddrb4_pkg;
    // Width of one byte-write lane, in bits.
    localparam int LANE_W     = 9;
    // Beats per burst; fixed by the burst-of-four protocol.
    localparam int BEATS      = 4;
    localparam int BEAT_IDX_W = $clog2(BEATS);

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_FILL = 1'b1
    } wr_state_e;

    function automatic int lanes_of(input int width);
        return width / LANE_W;
    endfunction
endpackage

// File: rtl/ddrb4_array.sv
`timescale 1ns/1ps
module ddrb4_array #(
    parameter int WORD_W = 72,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] wmask,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Bitwise merge: bits with a set mask take the new value.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ddrb4_wr_collect.sv
`timescale 1ns/1ps
module ddrb4_wr_collect
    import ddrb4_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          beat_d,
    input  logic [DATA_W/LANE_W-1:0]   beat_be,
    output logic                       commit,
    output logic [ADDR_W-1:0]          commit_addr,
    output logic [DATA_W*BEATS-1:0]    commit_data,
    output logic [DATA_W*BEATS-1:0]    commit_mask
);
    localparam int WORD_W = DATA_W * BEATS;
    localparam int LANES  = lanes_of(DATA_W);
    localparam logic [BEAT_IDX_W-1:0] LAST = BEAT_IDX_W'(BEATS - 1);

    wr_state_e             st;
    logic [BEAT_IDX_W-1:0] cnt;
    logic [ADDR_W-1:0]     addr_q;
    logic [WORD_W-1:0]     data_q;
    logic [WORD_W-1:0]     mask_q;
    logic [DATA_W-1:0]     beat_m;

    // Spread each lane enable over its nine data bits.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign beat_m[l*LANE_W +: LANE_W] = {LANE_W{beat_be[l]}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= WR_IDLE;
            cnt    <= '0;
            addr_q <= '0;
            data_q <= '0;
            mask_q <= '0;
        end else if (st == WR_IDLE) begin
            if (start) begin
                st                  <= WR_FILL;
                cnt                 <= BEAT_IDX_W'(1);
                addr_q              <= addr;
                data_q[0 +: DATA_W] <= beat_d;
                mask_q[0 +: DATA_W] <= beat_m;
            end
        end else if (cnt == LAST) begin
            st <= WR_IDLE;
        end else begin
            data_q[cnt*DATA_W +: DATA_W] <= beat_d;
            mask_q[cnt*DATA_W +: DATA_W] <= beat_m;
            cnt                          <= cnt + 1'b1;
        end
    end

    // The last beat goes straight from the pins into the committed word.
    assign commit      = (st == WR_FILL) && (cnt == LAST);
    assign commit_addr = addr_q;
    always_comb begin
        commit_data = data_q;
        commit_mask = mask_q;
        commit_data[(BEATS-1)*DATA_W +: DATA_W] = beat_d;
        commit_mask[(BEATS-1)*DATA_W +: DATA_W] = beat_m;
    end

    // R3: once started, the collector stays busy until the fourth beat
    a_r3_fill_four: assert property (@(posedge clk) disable iff (rst)
        (st == WR_FILL && cnt != LAST) |=> (st == WR_FILL));
    // R8: exactly one commit per burst, then idle
    a_r8_one_commit: assert property (@(posedge clk) disable iff (rst)
        commit |=> (st == WR_IDLE));
    // R8: a command during a burst does not move the latched address
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (st == WR_FILL) |=> $stable(addr_q));
endmodule

// File: rtl/ddrb4_rd_pipe.sv
`timescale 1ns/1ps
module ddrb4_rd_pipe
    import ddrb4_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [ADDR_W-1:0]        addr,
    output logic [ADDR_W-1:0]        arr_addr,
    input  logic [DATA_W*BEATS-1:0]  arr_data,
    input  logic                     fwd_valid,
    input  logic [ADDR_W-1:0]        fwd_addr,
    input  logic [DATA_W*BEATS-1:0]  fwd_data,
    input  logic [DATA_W*BEATS-1:0]  fwd_mask,
    output logic [DATA_W-1:0]        rd_q,
    output logic                     rd_valid
);
    localparam int WORD_W = DATA_W * BEATS;
    localparam logic [BEAT_IDX_W-1:0] LAST = BEAT_IDX_W'(BEATS - 1);

    // Front stage: counts from the command tick to the fetch tick.
    logic                  f_busy;
    logic [BEAT_IDX_W-1:0] f_cnt;
    logic [ADDR_W-1:0]     f_addr;
    logic                  fetch;
    logic [WORD_W-1:0]     fetched;
    // Hand-off and output stages.
    logic                  hold_pend;
    logic [WORD_W-1:0]     hold_word;
    logic                  o_act;
    logic [BEAT_IDX_W-1:0] o_beat;
    logic [WORD_W-1:0]     o_word;

    assign arr_addr = f_addr;
    assign fetch    = f_busy && (f_cnt == LAST);

    // Forward a write whose last beat lands on the fetch tick.
    always_comb begin
        fetched = arr_data;
        if (fwd_valid && fwd_addr == f_addr) begin
            fetched = (arr_data & ~fwd_mask) | (fwd_data & fwd_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_busy    <= 1'b0;
            f_cnt     <= '0;
            f_addr    <= '0;
            hold_pend <= 1'b0;
            hold_word <= '0;
            o_act     <= 1'b0;
            o_beat    <= '0;
            o_word    <= '0;
            rd_q      <= '0;
            rd_valid  <= 1'b0;
        end else begin
            if (!f_busy) begin
                if (start) begin
                    f_busy <= 1'b1;
                    f_cnt  <= BEAT_IDX_W'(1);
                    f_addr <= addr;
                end
            end else if (fetch) begin
                f_busy <= 1'b0;
            end else begin
                f_cnt <= f_cnt + 1'b1;
            end

            if (o_act) begin
                rd_q     <= o_word[o_beat*DATA_W +: DATA_W];
                rd_valid <= 1'b1;
                o_beat   <= o_beat + 1'b1;
                if (o_beat == LAST) o_act <= 1'b0;
            end else begin
                rd_valid <= 1'b0;
            end

            if (hold_pend) begin
                o_word    <= hold_word;
                o_act     <= 1'b1;
                o_beat    <= '0;
                hold_pend <= 1'b0;
            end
            if (fetch) begin
                hold_word <= fetched;
                hold_pend <= 1'b1;
            end
        end
    end

    // R9: with no beat queued, the bus goes invalid and holds
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !o_act |=> (!rd_valid && $stable(rd_q)));
    // R6: a read run always lasts at least four beats
    a_r6_four_beats: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |=> rd_valid ##1 rd_valid ##1 rd_valid);
    // R8: the front stage ignores new commands until its fetch
    a_r8_front_busy: assert property (@(posedge clk) disable iff (rst)
        (f_busy && !fetch) |=> (f_busy && $stable(f_addr)));
endmodule

// File: rtl/ddr_burst4_sram.sv
`timescale 1ns/1ps
module ddr_burst4_sram
    import ddrb4_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     phase,
    input  logic                     rd_en,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [DATA_W/LANE_W-1:0] wr_be,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_valid
);
    localparam int WORD_W = DATA_W * BEATS;

    logic              wr_go, rd_go;
    logic              commit;
    logic [ADDR_W-1:0] c_addr, r_addr;
    logic [WORD_W-1:0] c_data, c_mask, r_data;

    // Commands count only on the first half of the external cycle.
    assign wr_go = wr_en && !phase;
    assign rd_go = rd_en && !phase;

    ddrb4_wr_collect #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst(rst), .start(wr_go), .addr(addr),
        .beat_d(wr_data), .beat_be(wr_be),
        .commit(commit), .commit_addr(c_addr),
        .commit_data(c_data), .commit_mask(c_mask)
    );

    ddrb4_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_array (
        .clk(clk), .we(commit), .waddr(c_addr), .wdata(c_data),
        .wmask(c_mask), .raddr(r_addr), .rdata(r_data)
    );

    ddrb4_rd_pipe #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst(rst), .start(rd_go), .addr(addr),
        .arr_addr(r_addr), .arr_data(r_data),
        .fwd_valid(commit), .fwd_addr(c_addr),
        .fwd_data(c_data), .fwd_mask(c_mask),
        .rd_q(rd_data), .rd_valid(rd_valid)
    );

    // R10: outputs are quiet in the tick after a reset tick
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> (!rd_valid && rd_data == '0));
endmodule

// File: tb/ddr_burst4_sram_tb.sv
`timescale 1ns/1ps
module ddr_burst4_sram_tb;
    import ddrb4_pkg::*;

    localparam int DW = 18;
    localparam int AW = 4;
    localparam int LN = DW / LANE_W;
    localparam int WW = DW * BEATS;
    localparam int MW = LN * BEATS;
    localparam logic [MW-1:0] FULL = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          phase = 1'b0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [LN-1:0] wr_be = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    ddr_burst4_sram #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .phase(phase), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .wr_be(wr_be),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int edge_n = 0;
    bit done = 1'b0;
    always @(posedge clk) edge_n <= edge_n + 1;

    // Reference model and queue of expected read bursts.
    logic [WW-1:0] ref_mem [1<<AW];
    logic [WW-1:0] exp_word [64];
    int            exp_edge [64];
    string         exp_tag [64];
    int ex_wr = 0, ex_rd = 0, ex_beat = 0;
    int rd_next_ok = 0, wr_next_ok = 0;
    logic [WW-1:0] wq_d = '0;
    logic [MW-1:0] wq_m = '0;
    int            wq_idx = BEATS;
    logic [DW-1:0] last_q = '0;

    // Beat checker: every valid beat must match the next expected beat on its tick.
    always @(negedge clk) begin
        if (!rst) begin
            n_chk++;
            if (rd_valid) begin
                if (ex_rd == ex_wr) begin
                    n_fail++;
                    $display("FAIL R6 unexpected beat actual=%h expected=no beat", rd_data);
                end else begin
                    if (rd_data !== exp_word[ex_rd][ex_beat*DW +: DW] ||
                        edge_n != exp_edge[ex_rd] + ex_beat) begin
                        n_fail++;
                        $display("FAIL %s beat %0d actual=%h@%0d expected=%h@%0d",
                                 exp_tag[ex_rd], ex_beat, rd_data, edge_n,
                                 exp_word[ex_rd][ex_beat*DW +: DW],
                                 exp_edge[ex_rd] + ex_beat);
                    end
                    if (ex_beat == BEATS-1) begin
                        ex_beat = 0;
                        ex_rd++;
                    end else begin
                        ex_beat++;
                    end
                end
            end else if (rd_data !== last_q) begin
                n_fail++;
                $display("FAIL R9 idle bus changed actual=%h expected=%h", rd_data, last_q);
            end
            last_q = rd_data;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        phase = ~phase;
        rd_en = 1'b0;
        wr_en = 1'b0;
        if (wq_idx < BEATS) begin
            wr_data = wq_d[wq_idx*DW +: DW];
            wr_be   = wq_m[wq_idx*LN +: LN];
            wq_idx++;
        end else begin
            wr_data = '0;
            wr_be   = '0;
        end
    endtask

    task automatic align();
        tick();
        if (phase) tick();
    endtask

    // Drive a command for the coming tick; the model applies the same acceptance rules.
    task automatic cmd(input bit rd, input bit wr, input logic [AW-1:0] a,
                       input logic [WW-1:0] wd, input logic [MW-1:0] wm, input string tag);
        int ce;
        ce = edge_n + 1;
        addr  = a;
        rd_en = rd;
        wr_en = wr;
        if (wr && !phase && ce >= wr_next_ok) begin
            wr_next_ok = ce + 4;
            wq_d = wd; wq_m = wm; wq_idx = 1;
            wr_data = wd[DW-1:0];
            wr_be   = wm[LN-1:0];
            for (int b = 0; b < BEATS; b++)
                for (int l = 0; l < LN; l++)
                    if (wm[b*LN + l])
                        ref_mem[a][b*DW + l*LANE_W +: LANE_W] = wd[b*DW + l*LANE_W +: LANE_W];
        end
        if (rd && !phase && ce >= rd_next_ok) begin
            rd_next_ok = ce + 4;
            exp_word[ex_wr] = ref_mem[a];
            exp_edge[ex_wr] = ce + 5;
            exp_tag[ex_wr]  = tag;
            ex_wr++;
        end
    endtask

    task automatic drain(input string tag);
        repeat (12) tick();
        chk(ex_rd == ex_wr, tag, WW'(ex_rd), WW'(ex_wr));
    endtask

    task automatic full_write(input logic [AW-1:0] a, input logic [WW-1:0] d);
        align();
        cmd(1'b0, 1'b1, a, d, FULL, "R3");
        repeat (4) tick();
    endtask

    task automatic read_one(input logic [AW-1:0] a, input string tag);
        align();
        cmd(1'b1, 1'b0, a, '0, '0, tag);
    endtask

    task automatic t_reset();
        chk(rd_valid == 1'b0, "R10 valid", WW'(rd_valid), '0);
        chk(rd_data == '0, "R10 data", WW'(rd_data), '0);
    endtask

    task automatic t_basic();
        full_write(4'd3, 72'h0A_1234_5678_9ABC_DEF0);
        full_write(4'd12, 72'h5F_0F0F_F0F0_3C3C_C3C3);
        read_one(4'd3, "R6");
        read_one(4'd12, "R5");
        read_one(4'd3, "R5");
        drain("R3");
    endtask

    task automatic t_lanes();
        full_write(4'd5, 72'hFF_FFFF_FFFF_FFFF_FFFF);
        align();
        cmd(1'b0, 1'b1, 4'd5, 72'h00_0000_0000_0000_0000, 8'b10_01_00_11, "R4");
        repeat (4) tick();
        read_one(4'd5, "R4");
        drain("R4");
    endtask

    task automatic t_same_tick();
        full_write(4'd7, 72'h11_1111_1111_1111_1111);
        align();
        cmd(1'b1, 1'b1, 4'd7, 72'h22_2222_2222_2222_2222, 8'b01_11_10_11, "R1 R7 same tick");
        drain("R1");
    endtask

    task automatic t_read_then_write();
        full_write(4'd8, 72'h33_3333_3333_3333_3333);
        align();
        cmd(1'b1, 1'b0, 4'd8, '0, '0, "R7 read before write");
        tick(); tick();
        cmd(1'b0, 1'b1, 4'd8, 72'h44_4444_4444_4444_4444, FULL, "R7");
        repeat (4) tick();
        read_one(4'd8, "R7 later read");
        drain("R7");
    endtask

    task automatic t_write_then_read();
        align();
        cmd(1'b0, 1'b1, 4'd9, 72'h55_5555_5555_5555_5555, FULL, "R7");
        tick(); tick();
        cmd(1'b1, 1'b0, 4'd9, '0, '0, "R7 write before read");
        drain("R7");
    endtask

    task automatic t_phase();
        full_write(4'd10, 72'h66_6666_6666_6666_6666);
        align();
        tick();
        cmd(1'b1, 1'b1, 4'd10, 72'h77_7777_7777_7777_7777, FULL, "R2");
        repeat (8) tick();
        read_one(4'd10, "R2 wrong phase write ignored");
        drain("R2");
    endtask

    task automatic t_busy();
        full_write(4'd11, 72'h88_8888_8888_8888_8888);
        full_write(4'd13, 72'h99_9999_9999_9999_9999);
        align();
        cmd(1'b0, 1'b1, 4'd11, 72'hAA_AAAA_AAAA_AAAA_AAAA, FULL, "R8");
        tick(); tick();
        cmd(1'b0, 1'b1, 4'd13, 72'hBB_BBBB_BBBB_BBBB_BBBB, FULL, "R8");
        repeat (4) tick();
        read_one(4'd13, "R8 busy write ignored");
        tick(); tick();
        cmd(1'b1, 1'b0, 4'd11, '0, '0, "R8 busy read ignored");
        tick(); tick();
        cmd(1'b1, 1'b0, 4'd11, '0, '0, "R8 back-to-back");
        drain("R8");
    endtask

    initial begin
        repeat (4) tick();
        t_reset();
        rst = 1'b0;
        t_basic();
        t_lanes();
        t_same_tick();
        t_read_then_write();
        t_write_then_read();
        t_phase();
        t_busy();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R6 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule